// File: doc/BRIEF.md
# Multi-Channel Wiper Register Command Engine

This block sits behind a two-wire serial slave front end and executes the command bytes it receives. It owns a small register file of digitally controlled resistor channels. Each channel has one volatile wiper word, which drives the tap switches of its resistor array, and a bank of nonvolatile data words. The front end handles addressing and bit timing. It hands the engine byte-level events: a frame start, each received byte, the stop condition, and up/down step pulses while in step mode. The engine answers each byte with an acknowledge bit one cycle later and supplies read data. It also reports when it is busy so the front end can refuse new traffic during a nonvolatile write.

Every register word is eight bits. Bit 7 selects cascade mode, bit 6 disables the wiper, and the low bits hold the tap position. Any change to a data word is treated as a nonvolatile write. That write is committed at the stop condition and holds the engine busy for a parameterised number of clock cycles. When reset is released, each wiper word is loaded from data word 0 of its own channel.

Top module: `wce_top`

## Requirements
- R1: After reset release, by the second rising clock edge, every channel's wiper word equals its data word 0, and busy is low. Each data word powers up as (NV_SEED + 37*(4*channel + index)) mod 256.
- R2: The first byte of a frame is decoded as opcode = bits 7:4, channel = bits 3:2, data-word index = bits 1:0. The defined opcodes are 0x9, 0xA, 0xB, 0xC, 0xD, 0xE, 0x1, 0x8 and 0x2. These are acknowledged (ack=1 one cycle after the byte). Any other opcode is refused (ack=0) and changes no register.
- R3: Opcode 0xA followed by one data byte and a stop loads the data byte into the addressed wiper word. The new value is visible the cycle after the stop and not before it.
- R4: Opcode 0xC followed by one data byte and a stop loads the addressed data word and raises busy the cycle after the stop.
- R5: Opcodes 0x9 (wiper word) and 0xB (data word) raise rd_vld with the addressed word on rd_data from the cycle after the command byte until the stop.
- R6: Opcode 0xD with a stop copies data word [index] into the addressed channel's wiper word. Opcode 0xE with a stop copies the wiper word into data word [index] and raises busy.
- R7: Opcode 0x1 loads every channel's wiper word from its own data word [index]. Opcode 0x8 stores every wiper word into its own data word [index] and raises busy. Both ignore the channel field.
- R8: Busy stays high for exactly NV_BUSY_CYC cycles after a nonvolatile commit. While busy, every byte is refused with ack=0 and no frame commits.
- R9: A write or transfer frame whose byte count does not match its opcode, or that is cut off by a new start before its stop, changes no register. A surplus byte is refused.
- R10: After an acknowledged 0x2 command, each step pulse moves the addressed tap one position up (step_up=1) or down. The tap saturates at all-ones and at zero, and bits 7:6 are kept. Step pulses outside that mode, or after the stop, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| fe_start | input | 1 | Start or repeated-start event, one cycle |
| fe_stop | input | 1 | Stop event, one cycle |
| fe_byte_vld | input | 1 | A received byte is on fe_byte, one cycle |
| fe_byte | input | 8 | Received byte |
| fe_step | input | 1 | Step pulse in step mode |
| fe_step_up | input | 1 | Step direction, 1 = toward high end |
| ack_vld | output | 1 | Acknowledge decision valid (cycle after fe_byte_vld) |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_vld | output | 1 | Read data is being supplied |
| rd_data | output | 8 | Addressed register word for a read frame |
| step_mode | output | 1 | Step mode active |
| busy | output | 1 | Power-up recall or nonvolatile write in progress |
| wiper_word | output | NUM_CH*8 | All wiper words, channel 0 in the low byte |

## Verification
The embedded properties assume the front end behaves well. Start, stop, byte and step events arrive as single-cycle pulses, never two in the same cycle, and step pulses come only inside a frame. The bench drives every event through one task at a time, each holding its pulse for exactly one clock. Random traffic therefore keeps the events mutually exclusive, while still mixing opcodes, channels, indices and data values. The bench waits for busy to fall before the next random command and checks refusal during busy as a directed case.

// File: rtl/wce_pkg.sv
package wce_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      OP_GDR2W  = 4'b0001,
      OP_STEP   = 4'b0010,
      OP_GW2DR  = 4'b1000,
      OP_RDW    = 4'b1001,
      OP_WRW    = 4'b1010,
      OP_RDDR   = 4'b1011,
      OP_WRDR   = 4'b1100,
      OP_DR2W   = 4'b1101,
      OP_W2DR   = 4'b1110
   } op_e;

   typedef struct packed {
      logic [3:0] op;
      logic [1:0] pot;
      logic [1:0] idx;
   } instr_t;

   function automatic logic op_known(input logic [3:0] o);
      case (o)
         OP_GDR2W, OP_STEP, OP_GW2DR, OP_RDW, OP_WRW,
         OP_RDDR, OP_WRDR, OP_DR2W, OP_W2DR: return 1'b1;
         default:                             return 1'b0;
      endcase
   endfunction

   function automatic logic op_is_write(input logic [3:0] o);
      return (o == OP_WRW) || (o == OP_WRDR);
   endfunction

   function automatic logic op_is_read(input logic [3:0] o);
      return (o == OP_RDW) || (o == OP_RDDR);
   endfunction

   function automatic logic op_is_nv(input logic [3:0] o);
      return (o == OP_WRDR) || (o == OP_W2DR) || (o == OP_GW2DR);
   endfunction

   // bytes after the slave address that a complete frame carries
   function automatic logic [1:0] op_len(input logic [3:0] o);
      return op_is_write(o) ? 2'd2 : 2'd1;
   endfunction

   function automatic logic [BYTE_W-1:0] nv_init(input logic [BYTE_W-1:0] seed,
                                                 input int ch, input int ix);
      return seed + BYTE_W'((37 * (4 * ch + ix)) % 256);
   endfunction

endpackage

// File: rtl/wce_nv_timer.sv
module wce_nv_timer #(
   parameter int NV_BUSY_CYC = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic nv_busy
);
   localparam int CW = $clog2(NV_BUSY_CYC + 1);

   if (NV_BUSY_CYC < 1) begin : g_bad_len
      $error("NV_BUSY_CYC must be at least 1");
   end

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               remain <= '0;
      else if (start)           remain <= CW'(NV_BUSY_CYC);
      else if (remain != '0)    remain <= remain - 1'b1;
   end

   assign nv_busy = (remain != '0);

   p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> nv_busy);

endmodule

// File: rtl/wce_frame_dec.sv
module wce_frame_dec
   import wce_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fe_start,
   input  logic              fe_stop,
   input  logic              fe_byte_vld,
   input  logic [BYTE_W-1:0] fe_byte,
   input  logic              fe_step,
   input  logic              busy,
   output logic              ack_vld,
   output logic              ack,
   output logic              rd_act,
   output logic              step_act,
   output logic              step_en,
   output logic              commit,
   output instr_t            instr_o,
   output logic [BYTE_W-1:0] data_o
);
   logic       alive, dead;
   logic [1:0] cnt;
   logic       byte_ok;

   always_comb begin
      byte_ok = 1'b0;
      if (alive && !dead && !busy) begin
         if (cnt == 2'd0)      byte_ok = op_known(fe_byte[7:4]);
         else if (cnt == 2'd1) byte_ok = op_is_write(instr_o.op);
      end
   end

   assign commit  = fe_stop && alive && !dead && !busy && (cnt == op_len(instr_o.op));
   assign step_en = fe_step && step_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alive    <= 1'b0;
         dead     <= 1'b0;
         cnt      <= '0;
         rd_act   <= 1'b0;
         step_act <= 1'b0;
         instr_o  <= '0;
         data_o   <= '0;
         ack_vld  <= 1'b0;
         ack      <= 1'b0;
      end else begin
         ack_vld <= fe_byte_vld;
         ack     <= fe_byte_vld && byte_ok;
         if (fe_start) begin
            alive    <= 1'b1;
            dead     <= busy;
            cnt      <= '0;
            rd_act   <= 1'b0;
            step_act <= 1'b0;
         end else if (fe_stop) begin
            alive    <= 1'b0;
            rd_act   <= 1'b0;
            step_act <= 1'b0;
         end else if (fe_byte_vld && alive) begin
            if (cnt != 2'd3) cnt <= cnt + 2'd1;
            if (!byte_ok) begin
               dead     <= 1'b1;
               rd_act   <= 1'b0;
               step_act <= 1'b0;
            end else if (cnt == 2'd0) begin
               instr_o  <= instr_t'(fe_byte);
               rd_act   <= op_is_read(fe_byte[7:4]);
               step_act <= (fe_byte[7:4] == OP_STEP);
            end else begin
               data_o <= fe_byte;
            end
         end
      end
   end

   p_undef_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_byte_vld && alive && cnt == 2'd0 && !op_known(fe_byte[7:4])) |=> (ack_vld && !ack));

   p_surplus_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_byte_vld && alive && cnt == 2'd1 && !op_is_write(instr_o.op)) |=> !ack);

endmodule

// File: rtl/wce_chan.sv
module wce_chan
   import wce_pkg::*;
#(
   parameter int              NUM_DR  = 4,
   parameter int              TAP_W   = 6,
   parameter int              CH_IDX  = 0,
   parameter logic [BYTE_W-1:0] NV_SEED = 8'h5A
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     recall,
   input  logic                     w_ld,
   input  logic                     w_xfer,
   input  logic                     d_ld,
   input  logic                     d_xfer,
   input  logic [1:0]               sel,
   input  logic [BYTE_W-1:0]        data,
   input  logic                     step_en,
   input  logic                     step_up,
   output logic [BYTE_W-1:0]        wiper,
   output logic [NUM_DR*BYTE_W-1:0] dr_flat
);
   localparam logic [TAP_W-1:0] TAP_MAX = '1;

   logic [BYTE_W-1:0] dr [NUM_DR];
   logic [BYTE_W-1:0] stepped;
   logic [TAP_W-1:0]  tap;
   logic              sel_ok;

   assign sel_ok = (int'(sel) < NUM_DR);
   assign tap    = wiper[TAP_W-1:0];

   always_comb begin
      stepped = wiper;
      if (step_up) begin
         if (tap != TAP_MAX) stepped[TAP_W-1:0] = tap + 1'b1;
      end else begin
         if (tap != '0)      stepped[TAP_W-1:0] = tap - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wiper <= '0;
         for (int r = 0; r < NUM_DR; r++) dr[r] <= nv_init(NV_SEED, CH_IDX, r);
      end else begin
         if (recall)                wiper <= dr[0];
         else if (w_ld)             wiper <= data;
         else if (w_xfer && sel_ok) wiper <= dr[sel];
         else if (step_en)          wiper <= stepped;
         if (sel_ok) begin
            if (d_ld)        dr[sel] <= data;
            else if (d_xfer) dr[sel] <= wiper;
         end
      end
   end

   for (genvar r = 0; r < NUM_DR; r++) begin : g_flat
      assign dr_flat[r*BYTE_W +: BYTE_W] = dr[r];
   end

   p_recall_r1: assert property (@(posedge clk) disable iff (!rst_n)
      recall |=> (wiper == $past(dr_flat[BYTE_W-1:0])));

   p_step_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && step_up && !recall && !w_ld && !w_xfer && (tap == TAP_MAX))
      |=> (wiper[TAP_W-1:0] == TAP_MAX));

   p_step_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !step_up && !recall && !w_ld && !w_xfer && (tap == '0))
      |=> (wiper[TAP_W-1:0] == '0));

   p_step_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !recall && !w_ld && !w_xfer) |=> $stable(wiper[BYTE_W-1:TAP_W]));

endmodule

// File: rtl/wce_top.sv
module wce_top
   import wce_pkg::*;
#(
   parameter int                NUM_CH      = 4,
   parameter int                NUM_DR      = 4,
   parameter int                TAP_W       = 6,
   parameter int                NV_BUSY_CYC = 500000,
   parameter logic [BYTE_W-1:0] NV_SEED     = 8'h5A
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fe_start,
   input  logic                     fe_stop,
   input  logic                     fe_byte_vld,
   input  logic [BYTE_W-1:0]        fe_byte,
   input  logic                     fe_step,
   input  logic                     fe_step_up,
   output logic                     ack_vld,
   output logic                     ack,
   output logic                     rd_vld,
   output logic [BYTE_W-1:0]        rd_data,
   output logic                     step_mode,
   output logic                     busy,
   output logic [NUM_CH*BYTE_W-1:0] wiper_word
);
   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("NUM_CH must lie in 1..4 (two-bit channel field)");
   end
   if (NUM_DR < 1 || NUM_DR > 4) begin : g_bad_dr
      $error("NUM_DR must lie in 1..4 (two-bit index field)");
   end
   if (TAP_W < 1 || TAP_W > BYTE_W - 2) begin : g_bad_tap
      $error("TAP_W must leave bits 7:6 for the mode flags");
   end

   instr_t            instr;
   logic [BYTE_W-1:0] hdata;
   logic              commit, step_en, nv_busy, recall_q, nv_start;

   wce_frame_dec u_dec (
      .clk, .rst_n, .fe_start, .fe_stop, .fe_byte_vld, .fe_byte, .fe_step,
      .busy, .ack_vld, .ack, .rd_act(rd_vld), .step_act(step_mode),
      .step_en, .commit, .instr_o(instr), .data_o(hdata)
   );

   assign nv_start = commit && op_is_nv(instr.op);

   wce_nv_timer #(.NV_BUSY_CYC(NV_BUSY_CYC)) u_timer (
      .clk, .rst_n, .start(nv_start), .nv_busy
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) recall_q <= 1'b1;
      else        recall_q <= 1'b0;
   end

   assign busy = nv_busy || recall_q;

   logic [BYTE_W-1:0]        wip [NUM_CH];
   logic [NUM_DR*BYTE_W-1:0] drs [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = (int'(instr.pot) == c);

      wce_chan #(
         .NUM_DR(NUM_DR), .TAP_W(TAP_W), .CH_IDX(c), .NV_SEED(NV_SEED)
      ) u_chan (
         .clk, .rst_n,
         .recall (recall_q),
         .w_ld   (commit && hit && instr.op == OP_WRW),
         .w_xfer (commit && ((hit && instr.op == OP_DR2W) || instr.op == OP_GDR2W)),
         .d_ld   (commit && hit && instr.op == OP_WRDR),
         .d_xfer (commit && ((hit && instr.op == OP_W2DR) || instr.op == OP_GW2DR)),
         .sel    (instr.idx),
         .data   (hdata),
         .step_en(step_en && hit),
         .step_up(fe_step_up),
         .wiper  (wip[c]),
         .dr_flat(drs[c])
      );

      assign wiper_word[c*BYTE_W +: BYTE_W] = wip[c];
   end

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (int'(instr.pot) == c) begin
            if (instr.op == OP_RDW)           rd_data = wip[c];
            else if (int'(instr.idx) < NUM_DR) rd_data = drs[c][instr.idx*BYTE_W +: BYTE_W];
         end
      end
   end

   p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_byte_vld && busy) |=> !ack);

   p_no_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !commit);

   p_nv_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && (instr.op == OP_W2DR || instr.op == OP_GW2DR)) |=> busy);

endmodule

// File: tb/tb_wce_top.sv
`timescale 1ns/1ps
module tb_wce_top;
   localparam int NCH = 4;
   localparam int NDR = 4;
   localparam int BUSY_N = 20;
   localparam logic [7:0] SEED = 8'h5A;

   logic clk = 1'b0, rst_n = 1'b0;
   logic fe_start = 0, fe_stop = 0, fe_byte_vld = 0, fe_step = 0, fe_step_up = 0;
   logic [7:0] fe_byte = '0;
   logic ack_vld, ack, rd_vld, step_mode, busy;
   logic [7:0] rd_data;
   logic [NCH*8-1:0] wiper_word;

   int errors = 0, checks = 0;
   bit done = 0;
   logic [7:0] mw [NCH];
   logic [7:0] md [NCH][NDR];
   logic last_ack;

   always #10 clk = ~clk;

   wce_top #(.NUM_CH(NCH), .NUM_DR(NDR), .TAP_W(6), .NV_BUSY_CYC(BUSY_N), .NV_SEED(SEED)) dut (
      .clk, .rst_n, .fe_start, .fe_stop, .fe_byte_vld, .fe_byte, .fe_step, .fe_step_up,
      .ack_vld, .ack, .rd_vld, .rd_data, .step_mode, .busy, .wiper_word);

   function automatic logic [7:0] init_val(int c, int r);
      return SEED + 8'((37 * (4 * c + r)) % 256);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] wv(int c);
      return wiper_word[c*8 +: 8];
   endfunction

   task automatic chk_wipers(input string req);
      for (int c = 0; c < NCH; c++) chk(req, wv(c), mw[c]);
   endtask

   task automatic ev_start;  fe_start = 1; @(posedge clk); #1 fe_start = 0; endtask
   task automatic ev_stop;   fe_stop = 1;  @(posedge clk); #1 fe_stop = 0;  endtask
   task automatic ev_byte(input logic [7:0] b);
      fe_byte = b; fe_byte_vld = 1; @(posedge clk); #1 fe_byte_vld = 0;
      last_ack = ack;
   endtask
   task automatic ev_step(input logic up);
      fe_step = 1; fe_step_up = up; @(posedge clk); #1 fe_step = 0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 1000) begin @(posedge clk); #1 n++; end
   endtask

   // update the bench model for a committed command
   task automatic model(input logic [7:0] ins, input logic [7:0] d);
      int p = ins[3:2], r = ins[1:0];
      case (ins[7:4])
         4'hA: mw[p] = d;
         4'hC: md[p][r] = d;
         4'hD: mw[p] = md[p][r];
         4'hE: md[p][r] = mw[p];
         4'h1: for (int c = 0; c < NCH; c++) mw[c] = md[c][r];
         4'h8: for (int c = 0; c < NCH; c++) md[c][r] = mw[c];
         default: ;
      endcase
   endtask

   task automatic frame2(input logic [7:0] ins);
      int n;
      ev_start; ev_byte(ins); ev_stop; model(ins, 8'h00); wait_idle(n);
   endtask

   task automatic frame3(input logic [7:0] ins, input logic [7:0] d);
      int n;
      ev_start; ev_byte(ins); ev_byte(d); ev_stop; model(ins, d); wait_idle(n);
   endtask

   task automatic rd_word(input logic [7:0] ins, output logic [7:0] v, output logic ok);
      ev_start; ev_byte(ins); ok = last_ack && rd_vld; v = rd_data; ev_stop;
   endtask

   initial begin
      logic [7:0] v, w0;
      logic ok;
      int n;
      int unsigned sd;
      sd = $urandom(32'd4242);
      for (int c = 0; c < NCH; c++)
         for (int r = 0; r < NDR; r++) md[c][r] = init_val(c, r);
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(posedge clk); #1;
      // R1: recall of data word 0
      for (int c = 0; c < NCH; c++) mw[c] = md[c][0];
      chk_wipers("R1 recall");
      chk("R1 busy low", busy, 0);
      chk("R5 rd_vld idle", rd_vld, 0);

      // R3: wiper write not visible before stop
      ev_start; ev_byte(8'hA8); chk("R2 ack 0xA", last_ack, 1);
      ev_byte(8'h7F); chk("R3 data ack", last_ack, 1);
      chk("R3 before stop", wv(2), mw[2]);
      ev_stop; model(8'hA8, 8'h7F);
      chk("R3 after stop", wv(2), 8'h7F);

      // R5: read back wiper and data word
      rd_word(8'h98, v, ok); chk("R5 rd wiper ok", ok, 1); chk("R5 rd wiper", v, 8'h7F);
      rd_word(8'hB7, v, ok); chk("R5 rd dr", v, md[1][3]);

      // R4 + R8: data write, busy length and refusal
      ev_start; ev_byte(8'hC7); ev_byte(8'h55); ev_stop; model(8'hC7, 8'h55);
      chk("R4 busy after stop", busy, 1);
      wait_idle(n); chk("R8 busy length", n, BUSY_N);
      rd_word(8'hB7, v, ok); chk("R4 rd dr", v, 8'h55);
      ev_start; ev_byte(8'hC0); ev_byte(8'h11); ev_stop; model(8'hC0, 8'h11);
      ev_start; ev_byte(8'h94); chk("R8 nack busy", last_ack, 0);
      chk("R8 no rd busy", rd_vld, 0); ev_stop;
      ev_start; ev_byte(8'hA4); ev_byte(8'h01); ev_stop;
      chk("R8 no write busy", wv(1), mw[1]);
      wait_idle(n);

      // R2: undefined opcodes refused, no change
      foreach (mw[c]) ;
      ev_start; ev_byte(8'h3C); chk("R2 undef nack", last_ack, 0);
      ev_byte(8'h00); chk("R2 undef data nack", last_ack, 0); ev_stop;
      ev_start; ev_byte(8'hF0); chk("R2 undef 0xF", last_ack, 0); ev_stop;
      chk("R2 busy stays low", busy, 0);
      chk_wipers("R2 unchanged");

      // R6: single transfers
      frame2(8'hD7); chk("R6 dr->w", wv(1), 8'h55);
      frame2(8'hE2); rd_word(8'hB2, v, ok); chk("R6 w->dr", v, mw[0]);

      // R7: global transfers ignore channel field
      frame2(8'h1E); chk_wipers("R7 global dr->w");
      frame3(8'hA0, 8'h21); frame3(8'hA4, 8'h22);
      frame2(8'h89);
      for (int c = 0; c < NCH; c++) begin
         rd_word(8'hB1 | 8'(c << 2), v, ok); chk("R7 global w->dr", v, md[c][1]);
      end

      // R9: bad byte count, cut-off frames
      w0 = wv(0);
      ev_start; ev_byte(8'hA0); ev_stop; chk("R9 short write", wv(0), w0);
      ev_start; ev_byte(8'hA0); ev_byte(8'h3A); ev_start; ev_stop;
      chk("R9 restart discard", wv(0), w0);
      ev_start; ev_byte(8'hD3); ev_byte(8'h00); chk("R9 surplus nack", last_ack, 0); ev_stop;
      chk("R9 surplus discard", wv(0), w0);
      chk("R9 no busy", busy, 0);

      // R10: step mode
      frame3(8'hAC, 8'h7E);
      ev_start; ev_byte(8'h2C); chk("R10 step ack", last_ack, 1);
      chk("R10 mode on", step_mode, 1);
      ev_step(1); chk("R10 up", wv(3), 8'h7F);
      ev_step(1); chk("R10 sat high", wv(3), 8'h7F);
      ev_stop; mw[3] = 8'h7F;
      ev_step(0); chk("R10 step outside mode", wv(3), 8'h7F);
      frame3(8'hAC, 8'hC1);
      ev_start; ev_byte(8'h2C);
      ev_step(0); chk("R10 down", wv(3), 8'hC0);
      ev_step(0); chk("R10 sat low", wv(3), 8'hC0);
      ev_stop; mw[3] = 8'hC0;
      chk_wipers("R10 others");

      // random mix
      for (int i = 0; i < 60; i++) begin
         logic [7:0] ins, d;
         logic [3:0] ops [7] = '{4'hA, 4'hC, 4'hD, 4'hE, 4'h1, 4'h8, 4'hB};
         logic [3:0] op;
         op  = ops[$urandom_range(0, 6)];
         ins = {op, 4'($urandom_range(0, 15))};
         d   = 8'($urandom_range(0, 255));
         if (op == 4'hB) begin
            rd_word(ins, v, ok); chk("R5 random rd", v, md[ins[3:2]][ins[1:0]]);
         end else if (op == 4'hA || op == 4'hC) begin
            frame3(ins, d);
         end else begin
            frame2(ins);
         end
         chk_wipers(op == 4'h1 ? "R7 random" : (op == 4'hA ? "R3 random" : "R6 random"));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      done = 1;
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule